// File: doc/BRIEF.md
# Multichannel DAC Serial Register Interface

This block is the digital control side of a multichannel DAC. It receives 24-bit command words over a four-wire serial link, where the link clock idles low and data is captured on its falling edge. Each word carries a two-bit mode, a six-bit register address and a sixteen-bit payload. The block decodes the word into a write to one channel's data, offset or gain register, a shared per-reference group offset register, or the control register. A special command asks for a register to be returned, and the block shifts that value out during the next word. From each channel's data, gain and offset it computes a corrected output code. It also drives a global power-down flag.

The serial inputs pass through synchronizers into the system clock domain. A three-state receiver controls the transfer. It waits in `RX_IDLE` while chip select is high. When chip select falls it moves to `RX_SHIFT`, where it counts and shifts bits on falling serial-clock edges and drives return bits on rising ones. When chip select rises it moves to `RX_COMMIT` for one cycle, where a word of exactly 24 bits is handed to the register bank. It then returns to `RX_IDLE`. The channel count, channels per group, number of group offset registers and code resolution (16 or 14 bits) are parameters.

Top module: `mdac_spi_regif`

## Requirements
- R1: Bits are sampled MSB first on falling SCLK while CS is low, and the word is acted on when CS rises only if exactly 24 bits arrived. A word of 23 or 25 bits changes no register and no output.
- R2: A word whose mode (bits 23:22) is 3 writes the data register of channel `addr-8`, where addr is bits 21:16, for 8 ≤ addr < 8+NUM_CH. The stored code is the payload (bits 15:0) shifted right by 16−RES. Addresses outside that window are ignored.
- R3: Mode 2 writes the channel offset register and mode 1 writes the channel gain register, with the same addressing and justification as R2.
- R4: A mode 0 word at address 0 changes nothing. A mode 0 word at address 1 sets the power-down output to payload bit 0.
- R5: A mode 0 word at address 2+g, with g < NUM_REF, sets group offset g to payload bits 13:0. Other mode 0 addresses up to 4 are ignored.
- R6: After reset, data and offset registers hold mid-scale (2^(RES−1)), gain registers hold all ones, group offsets hold 0x2000, and power-down is 0.
- R7: Each channel's output code is clamp(((data·(gain+1)) >> RES) + offset − 2^(RES−1)) to the range 0 … 2^RES−1.
- R8: A mode 0 word at address 5 is a readback request. Payload bits 15:13 give the type and bits 12:7 the address. In the next word, MISO carries 8 zero bits followed by the 16-bit value, MSB first, changing on rising SCLK.
- R9: The readback value is as follows. Type 0 returns the channel data, type 2 the offset and type 3 the gain, each left-justified in 16 bits and addressed as in R2. Type 4 returns control bit 0 at address 1 and group offset g at address 2+g. Type 1, types 5–7 and any unmapped address return zero.
- R10: The returned value stays pending across discarded words until the next accepted word. The word after an accepted non-readback word returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles low |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial command data |
| miso_o | output | 1 | Serial readback data |
| code_o | output | NUM_CH*RES | Corrected code per channel, channel 0 in the low bits |
| pwr_down_o | output | 1 | Global power-down flag |

## Verification
A corrupted channel register shows up on that channel's slice of `code_o` as soon as the write is committed, a few system clocks after CS rises. It also shows up in the low 16 bits of the word that follows a readback of that register. A wrong receiver state or bit count appears in two ways. Either a 23- or 25-bit word changes the outputs, or a valid word fails to, and both are visible right after CS rises. A stale or cleared pending readback appears on MISO within the first 24 bits of the next word.

// File: rtl/mdac_pkg.sv
package mdac_pkg;
    typedef enum logic [1:0] {
        MODE_SPECIAL = 2'd0,
        MODE_GAIN    = 2'd1,
        MODE_OFFSET  = 2'd2,
        MODE_DATA    = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e       mode;
        logic [5:0]  addr;
        logic [15:0] payload;
    } frame_t;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2
    } rx_state_e;

    localparam int FRAME_BITS = 24;
    localparam int CH_BASE    = 8;
    localparam int GRP_BITS   = 14;

    localparam logic [5:0] SF_NOP  = 6'd0;
    localparam logic [5:0] SF_CTRL = 6'd1;
    localparam logic [5:0] SF_GRP0 = 6'd2;
    localparam logic [5:0] SF_RDBK = 6'd5;

    localparam logic [2:0] RB_DATA_A = 3'd0;
    localparam logic [2:0] RB_OFFSET = 3'd2;
    localparam logic [2:0] RB_GAIN   = 3'd3;
    localparam logic [2:0] RB_SF     = 3'd4;
endpackage

// File: rtl/mdac_spi_rx.sv
module mdac_spi_rx
    import mdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_i,
    input  logic        cs_n_i,
    input  logic        mosi_i,
    input  logic [15:0] rb_word_i,
    output logic        miso_o,
    output logic        wr_en_o,
    output frame_t      frame_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic [2:0] sync_q [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 3'b010;
                else        sync_q[s] <= {sclk_i, cs_n_i, mosi_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 3'b010;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    logic sclk_s, cs_s, mosi_s, sclk_d;
    assign sclk_s = sync_q[SYNC_STAGES-1][2];
    assign cs_s   = sync_q[SYNC_STAGES-1][1];
    assign mosi_s = sync_q[SYNC_STAGES-1][0];

    logic sclk_rise, sclk_fall;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    rx_state_e state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [FRAME_BITS-1:0] rx_sr, tx_sr;
    logic miso_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (!cs_s) state_d = RX_SHIFT;
            RX_SHIFT:  if (cs_s)  state_d = RX_COMMIT;
            RX_COMMIT: state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            unique case (state_q)
                RX_IDLE: begin
                    miso_q <= 1'b0;
                    if (!cs_s) begin
                        bit_cnt <= '0;
                        tx_sr   <= {8'h00, rb_word_i};
                    end
                end
                RX_SHIFT: begin
                    if (sclk_fall) begin
                        rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
                        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (sclk_rise) begin
                        miso_q <= tx_sr[FRAME_BITS-1];
                        tx_sr  <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                    end
                end
                RX_COMMIT: miso_q <= 1'b0;
                default:   miso_q <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en_o = (state_q == RX_COMMIT) && (bit_cnt == CNT_FULL);
        frame_o = frame_t'(rx_sr);
        miso_o  = miso_q;
    end

    a_r1_commit_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(cs_s));
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_SAT);
    a_r1_commit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/mdac_regs.sv
module mdac_regs
    import mdac_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int RES     = 16,
    parameter int NUM_REF = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  frame_t                frame_i,
    output logic [NUM_CH*RES-1:0] data_o,
    output logic [NUM_CH*RES-1:0] gain_o,
    output logic [NUM_CH*RES-1:0] ofs_o,
    output logic                  pwr_o,
    output logic [15:0]           rb_word_o
);
    localparam int JUST = 16 - RES;
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);
    localparam logic [GRP_BITS-1:0] GRP_RST = 14'h2000;

    logic [RES-1:0] wr_code;
    logic [5:0] ch_off, rb_off;
    logic ch_hit, rb_hit, is_rdbk;
    logic [2:0] rb_type;
    logic [5:0] rb_addr;
    logic [NUM_REF*GRP_BITS-1:0] grp_flat;
    logic [15:0] rb_val;

    assign wr_code = RES'(frame_i.payload >> JUST);
    assign ch_off  = frame_i.addr - 6'(CH_BASE);
    assign ch_hit  = (frame_i.addr >= 6'(CH_BASE)) && (ch_off < 6'(NUM_CH));
    assign rb_type = frame_i.payload[15:13];
    assign rb_addr = frame_i.payload[12:7];
    assign rb_off  = rb_addr - 6'(CH_BASE);
    assign rb_hit  = (rb_addr >= 6'(CH_BASE)) && (rb_off < 6'(NUM_CH));
    assign is_rdbk = (frame_i.mode == MODE_SPECIAL) && (frame_i.addr == SF_RDBK);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [RES-1:0] d_q, g_q, o_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= MID;
                g_q <= '1;
                o_q <= MID;
            end else if (wr_en_i && ch_hit && ch_off == 6'(c)) begin
                case (frame_i.mode)
                    MODE_DATA:   d_q <= wr_code;
                    MODE_OFFSET: o_q <= wr_code;
                    MODE_GAIN:   g_q <= wr_code;
                    default:     ;
                endcase
            end
        end
        assign data_o[c*RES +: RES] = d_q;
        assign gain_o[c*RES +: RES] = g_q;
        assign ofs_o[c*RES +: RES]  = o_q;
    end

    for (genvar g = 0; g < NUM_REF; g++) begin : g_grp
        logic [GRP_BITS-1:0] grp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) grp_q <= GRP_RST;
            else if (wr_en_i && frame_i.mode == MODE_SPECIAL &&
                     frame_i.addr == SF_GRP0 + 6'(g))
                grp_q <= frame_i.payload[GRP_BITS-1:0];
        end
        assign grp_flat[g*GRP_BITS +: GRP_BITS] = grp_q;
    end

    always_comb begin
        rb_val = '0;
        case (rb_type)
            RB_DATA_A, RB_OFFSET, RB_GAIN: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rb_hit && rb_off == 6'(c)) begin
                        if (rb_type == RB_DATA_A)      rb_val = 16'(data_o[c*RES +: RES]) << JUST;
                        else if (rb_type == RB_OFFSET) rb_val = 16'(ofs_o[c*RES +: RES]) << JUST;
                        else                           rb_val = 16'(gain_o[c*RES +: RES]) << JUST;
                    end
                end
            end
            RB_SF: begin
                if (rb_addr == SF_CTRL) rb_val = {15'b0, pwr_o};
                for (int g = 0; g < NUM_REF; g++)
                    if (rb_addr == SF_GRP0 + 6'(g))
                        rb_val = {2'b00, grp_flat[g*GRP_BITS +: GRP_BITS]};
            end
            default: rb_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_o     <= 1'b0;
            rb_word_o <= '0;
        end else if (wr_en_i) begin
            if (frame_i.mode == MODE_SPECIAL && frame_i.addr == SF_CTRL)
                pwr_o <= frame_i.payload[0];
            rb_word_o <= is_rdbk ? rb_val : 16'h0000;
        end
    end

    a_r4_nop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && frame_i.mode == MODE_SPECIAL && frame_i.addr == SF_NOP)
        |=> ($stable(pwr_o) && $stable(grp_flat) && $stable(data_o) &&
             $stable(gain_o) && $stable(ofs_o)));
    a_r4_pwr_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(pwr_o));
    a_r10_rb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !is_rdbk) |=> (rb_word_o == 16'h0000));
    a_r10_rb_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rb_word_o));
endmodule

// File: rtl/mdac_correct.sv
module mdac_correct #(
    parameter int NUM_CH = 16,
    parameter int RES    = 16
) (
    input  logic [NUM_CH*RES-1:0] data_i,
    input  logic [NUM_CH*RES-1:0] gain_i,
    input  logic [NUM_CH*RES-1:0] ofs_i,
    output logic [NUM_CH*RES-1:0] code_o
);
    localparam int PW = 2*RES + 1;
    localparam int SW = RES + 3;
    localparam logic signed [SW-1:0] MID_S = SW'(1) << (RES - 1);
    localparam logic signed [SW-1:0] MAX_S = (SW'(1) << RES) - SW'(1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [RES:0]          gain_p1;
        logic [PW-1:0]         prod;
        logic [RES:0]          scaled;
        logic signed [SW-1:0]  sum;
        always_comb begin
            gain_p1 = {1'b0, gain_i[c*RES +: RES]} + 1'b1;
            prod    = PW'(data_i[c*RES +: RES]) * PW'(gain_p1);
            scaled  = prod[PW-1:RES];
            sum     = $signed({2'b00, scaled}) + $signed({3'b000, ofs_i[c*RES +: RES]}) - MID_S;
            if (sum < 0)          code_o[c*RES +: RES] = '0;
            else if (sum > MAX_S) code_o[c*RES +: RES] = '1;
            else                  code_o[c*RES +: RES] = sum[RES-1:0];
        end
    end
endmodule

// File: rtl/mdac_spi_regif.sv
module mdac_spi_regif
    import mdac_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int GROUP_SIZE = 8,
    parameter int NUM_REF    = 2,
    parameter int RES        = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  cs_n_i,
    input  logic                  mosi_i,
    output logic                  miso_o,
    output logic [NUM_CH*RES-1:0] code_o,
    output logic                  pwr_down_o
);
    localparam int NUM_GROUPS = (NUM_CH + GROUP_SIZE - 1) / GROUP_SIZE;
    localparam int USED_REF   = (NUM_GROUPS < NUM_REF) ? NUM_GROUPS : NUM_REF;
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);

    logic        wr_en;
    frame_t      frame;
    logic [15:0] rb_word;
    logic [NUM_CH*RES-1:0] data_w, gain_w, ofs_w;

    mdac_spi_rx #(.SYNC_STAGES(2)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .mosi_i    (mosi_i),
        .rb_word_i (rb_word),
        .miso_o    (miso_o),
        .wr_en_o   (wr_en),
        .frame_o   (frame)
    );

    mdac_regs #(.NUM_CH(NUM_CH), .RES(RES), .NUM_REF(USED_REF)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .frame_i   (frame),
        .data_o    (data_w),
        .gain_o    (gain_w),
        .ofs_o     (ofs_w),
        .pwr_o     (pwr_down_o),
        .rb_word_o (rb_word)
    );

    mdac_correct #(.NUM_CH(NUM_CH), .RES(RES)) u_corr (
        .data_i (data_w),
        .gain_i (gain_w),
        .ofs_i  (ofs_w),
        .code_o (code_o)
    );

    a_r7_unity_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_w[RES-1:0] == '1 && ofs_w[RES-1:0] == MID) |-> (code_o[RES-1:0] == data_w[RES-1:0]));
    a_r7_zero_data_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (data_w[RES-1:0] == '0 && ofs_w[RES-1:0] == '0) |-> (code_o[RES-1:0] == '0));
endmodule

// File: tb/tb_mdac_spi_regif.sv
module tb_mdac_spi_regif;
    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, mosi;
    logic miso, pwr;
    logic [NCH*16-1:0] code;

    always #10 clk = ~clk;

    mdac_spi_regif dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .code_o(code), .pwr_down_o(pwr)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    int m_data[NCH], m_gain[NCH], m_ofs[NCH];
    int m_grp[2];
    int m_pwr, exp_rb;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input int mode, input int addr, input int pl);
        return {mode[1:0], addr[5:0], pl[15:0]};
    endfunction

    function automatic logic [23:0] rbreq(input int typ, input int addr);
        return mk(0, 5, {typ[2:0], addr[5:0], 7'b0});
    endfunction

    function automatic int exp_code(input int d, input int g, input int o);
        longint p, s;
        p = longint'(d) * longint'(g + 1);
        s = (p >>> 16) + longint'(o) - 32768;
        if (s < 0) return 0;
        if (s > 65535) return 65535;
        return int'(s);
    endfunction

    function automatic int rb_model(input int typ, input int addr);
        int ch;
        ch = addr - 8;
        case (typ)
            0: return (ch >= 0 && ch < NCH) ? m_data[ch] : 0;
            2: return (ch >= 0 && ch < NCH) ? m_ofs[ch] : 0;
            3: return (ch >= 0 && ch < NCH) ? m_gain[ch] : 0;
            4: begin
                if (addr == 1) return m_pwr;
                if (addr == 2) return m_grp[0];
                if (addr == 3) return m_grp[1];
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    function automatic void apply(input logic [23:0] f);
        int mode, addr, pl, ch;
        mode = int'(f[23:22]); addr = int'(f[21:16]); pl = int'(f[15:0]);
        ch = addr - 8;
        if (mode != 0) begin
            if (ch >= 0 && ch < NCH) begin
                if (mode == 3) m_data[ch] = pl;
                if (mode == 2) m_ofs[ch] = pl;
                if (mode == 1) m_gain[ch] = pl;
            end
            exp_rb = 0;
        end else begin
            if (addr == 1) m_pwr = pl & 1;
            if (addr == 2) m_grp[0] = pl & 16'h3FFF;
            if (addr == 3) m_grp[1] = pl & 16'h3FFF;
            exp_rb = (addr == 5) ? rb_model(pl >> 13, (pl >> 7) & 6'h3F) : 0;
        end
    endfunction

    task automatic do_frame(input logic [31:0] bits, input int nbits, output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            mosi = bits[nbits-1-i];
            repeat (8) @(negedge clk);
            rx[nbits-1-i] = miso;
            sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        int bad_ch, got, want;
        bad_ch = -1; got = 0; want = 0;
        for (int c = 0; c < NCH; c++) begin
            if (bad_ch < 0 && int'(code[c*16 +: 16]) != exp_code(m_data[c], m_gain[c], m_ofs[c])) begin
                bad_ch = c;
                got = int'(code[c*16 +: 16]);
                want = exp_code(m_data[c], m_gain[c], m_ofs[c]);
            end
        end
        check(bad_ch < 0, {tag, " R7 code"}, got, want);
        check(int'(pwr) == m_pwr, {tag, " R4 pwr"}, int'(pwr), m_pwr);
    endtask

    // Full 24-bit word: check returned bits (R8/R10), update model, check outputs
    task automatic xfer(input logic [23:0] f, input string tag);
        logic [31:0] rx;
        do_frame({8'h0, f}, 24, rx);
        check(rx[23:0] == {8'h00, exp_rb[15:0]}, {tag, " R8 miso"}, int'(rx[23:0]), exp_rb);
        apply(f);
        check_outputs(tag);
    endtask

    initial begin
        logic [31:0] rx;
        logic [23:0] f;
        int mode, addr, pl;
        void'($urandom(32'd5150));
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            m_data[c] = 16'h8000; m_gain[c] = 16'hFFFF; m_ofs[c] = 16'h8000;
        end
        m_grp[0] = 16'h2000; m_grp[1] = 16'h2000; m_pwr = 0; exp_rb = 0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 reset state
        check_outputs("R6 reset");
        check(miso == 1'b0, "R6 miso idle", int'(miso), 0);
        xfer(rbreq(3, 11), "R6 gain rb");
        xfer(rbreq(2, 8), "R6 ofs rb");
        xfer(rbreq(4, 2), "R6 grp rb");
        xfer(rbreq(0, 23), "R6 data rb");
        xfer(mk(0, 0, 0), "R10 after rb");

        // R2 data writes, including ignored addresses
        xfer(mk(3, 8, 16'h1234), "R2 ch0");
        xfer(mk(3, 23, 16'hFFFF), "R2 ch15");
        xfer(mk(3, 24, 16'h0001), "R2 addr24 ignored");
        xfer(mk(3, 7, 16'h0002), "R2 addr7 ignored");

        // R3 offset and gain; R7 clamps
        xfer(mk(2, 9, 16'h9000), "R3 ofs ch1");
        xfer(mk(1, 9, 16'h7FFF), "R3 gain ch1");
        xfer(mk(3, 10, 16'h0000), "R7 ch2 data0");
        xfer(mk(2, 10, 16'h0000), "R7 clamp low");
        xfer(mk(3, 11, 16'hFFFF), "R7 ch3 full");
        xfer(mk(2, 11, 16'hFFFF), "R7 clamp high");

        // R4 control and no-op
        xfer(mk(0, 1, 16'hFFFF), "R4 pwr on");
        xfer(mk(0, 0, 16'hFFFF), "R4 nop");
        xfer(mk(0, 1, 16'hFFFE), "R4 pwr off");

        // R5 group offsets
        xfer(mk(0, 2, 16'h1ABC), "R5 grp0");
        xfer(mk(0, 3, 16'hFFFF), "R5 grp1 masked");
        xfer(mk(0, 4, 16'h0123), "R5 addr4 ignored");

        // R9 readback of each type
        xfer(rbreq(0, 8), "R9 data");
        xfer(rbreq(1, 8), "R9 type1");
        xfer(rbreq(2, 9), "R9 ofs");
        xfer(rbreq(3, 9), "R9 gain");
        xfer(rbreq(4, 2), "R9 grp0");
        xfer(rbreq(4, 3), "R9 grp1");
        xfer(rbreq(4, 4), "R9 sf unmapped");
        xfer(rbreq(5, 8), "R9 type5");
        xfer(rbreq(0, 30), "R9 ch unmapped");
        xfer(mk(0, 1, 16'h0001), "R9 pwr set");
        xfer(rbreq(4, 1), "R9 ctrl");
        xfer(mk(0, 0, 0), "R9 ctrl result");

        // R1 discarded frames, R10 pending value held across them
        xfer(rbreq(0, 8), "R10 request");
        do_frame({9'h0, mk(3, 12, 16'h4321)[22:0]}, 23, rx);
        check_outputs("R1 short frame");
        do_frame({7'h0, 1'b1, mk(3, 12, 16'h4321)}, 25, rx);
        check_outputs("R1 long frame");
        xfer(mk(0, 0, 0), "R10 held");
        xfer(mk(3, 12, 16'h4321), "R1 full frame");
        xfer(mk(0, 0, 0), "R10 cleared");

        // Constrained random mix
        for (int n = 0; n < 200; n++) begin
            mode = int'($urandom_range(0, 3));
            if (mode == 0) begin
                addr = int'($urandom_range(0, 7));
                if (addr == 5)
                    f = rbreq(int'($urandom_range(0, 7)),
                              ($urandom_range(0, 3) != 0) ? int'($urandom_range(0, 26)) : int'($urandom_range(0, 63)));
                else
                    f = mk(0, addr, int'($urandom_range(0, 65535)));
            end else begin
                addr = ($urandom_range(0, 9) < 8) ? int'($urandom_range(8, 23)) : int'($urandom_range(0, 63));
                pl = int'($urandom_range(0, 65535));
                f = mk(mode, addr, pl);
            end
            xfer(f, "R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule